// File: doc/BRIEF.md
# Microcontroller External Bus Decoder

This block sits beside an 8-bit microcontroller core and turns each code fetch or MOVX access into the right strobe on the right bus. The core starts an access with a one-cycle start pulse and supplies three things: the kind of access, a 16-bit address, and the current settings of three controls. Those controls are an SRAM-window select, a write-redirect bit and a 3-bit I/O strobe timing field. The decoder latches all of this and then drives one of the following for the length of the access: a program-memory strobe, an I/O strobe, an internal SRAM enable, or a runtime-register select.

The code space is flat. The 768-byte window starting at 0x0400 can be served either by internal SRAM or by external program memory. When the redirect bit is set, MOVX writes are sent to the program bus instead of the data bus. Data-space addresses are handled as follows:
- A few fixed data-space addresses are carved out as disk-interface task-file and alternate-status registers, each with its own chip select.
- A small reserved test window is silenced.
- The runtime-register page is kept internal.

External I/O strobes can be stretched so that slow peripherals keep working. While a strobe is stretched, a ready output holds the core.

Top module: `xbus_decoder`

## Requirements
- R1: A code fetch (kind 2'b00) to 0x0000-0x03FF or 0x0700-0xFFFF drives mem_rd_n low for exactly one cycle, with ext_addr equal to the fetch address.
- R2: An access on the program bus to 0x0400-0x06FF behaves as follows. With sram_sel=1 it asserts sram_en for one cycle, with sram_addr = address - 0x0400, and asserts no external strobe. With sram_sel=0 it uses the external program strobes like any other code address.
- R3: A MOVX write (kind 2'b10) behaves as follows. With wr_to_prog=0 it is a data-space write. With wr_to_prog=1 it goes to the program bus: an SRAM write (sram_we=1) inside the window when sram_sel=1, and a one-cycle mem_wr_n pulse otherwise.
- R4: A MOVX read (kind 2'b01) is always a data-space access, whatever the value of wr_to_prog.
- R5: A data-space access to 0x31F0-0x31F7 asserts ata_cs0_n low together with the I/O strobe, and drives ata_da with address bits [2:0].
- R6: A data-space access to 0x33F6 asserts ata_cs1_n low together with the I/O strobe, with ata_da = 3'd6. When neither chip select is active, ata_da is 0.
- R7: A data-space access to 0x30F0-0x30F3 asserts no strobe, no chip select, no sram_en and no sfr_sel. It still occupies one cycle of not-ready.
- R8: A data-space access to 0x0100-0x01FF asserts sfr_sel for one cycle and no external strobe.
- R9: Every other data-space address drives only io_rd_n or io_wr_n. The strobe lasts 1 + strobe_md cycles (strobe_md from 0 to 7), and the same applies to the disk-interface registers.
- R10: Program-bus strobes, SRAM accesses and runtime-register accesses last exactly one cycle. Throughout any access, acc_ready is low for exactly the cycles the access is active.
- R11: A start pulse is ignored if it arrives while acc_ready is low, or if it carries kind 2'b11.
- R12: After reset, all active-low strobes and chip selects are high, sram_en and sfr_sel are low, and acc_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_start | input | 1 | One-cycle access request |
| acc_kind | input | 2 | 00 fetch, 01 MOVX read, 10 MOVX write, 11 no access |
| acc_addr | input | 16 | Access address |
| sram_sel | input | 1 | 1: internal SRAM serves 0x0400-0x06FF |
| wr_to_prog | input | 1 | 1: MOVX writes go to the program bus |
| strobe_md | input | 3 | I/O strobe stretch, width = 1 + value |
| acc_ready | output | 1 | Low while an access is in progress |
| ext_addr | output | 16 | Latched address for external buses |
| mem_rd_n | output | 1 | Program memory read strobe |
| mem_wr_n | output | 1 | Program memory write strobe |
| io_rd_n | output | 1 | Data-space I/O read strobe |
| io_wr_n | output | 1 | Data-space I/O write strobe |
| sram_en | output | 1 | Internal SRAM access enable |
| sram_we | output | 1 | Internal SRAM write |
| sram_addr | output | 10 | Offset within the SRAM window |
| sfr_sel | output | 1 | Runtime-register page select |
| ata_cs0_n | output | 1 | Disk task-file chip select |
| ata_cs1_n | output | 1 | Disk alternate-register chip select |
| ata_da | output | 3 | Disk register address |

## Verification
Two functions can meet in the same cycle: acceptance of a new request and a stretched I/O strobe that is still running. The bench provokes this by raising a second start, with a different kind and address, while a 4-cycle I/O read is active. It judges the result at the ports: the scoreboard must see a single window of unchanged width and signature, and no second window. The same scoreboard also checks that the redirect control and the SRAM-window control interact correctly. It does this by sweeping each window boundary under all four combinations of the two controls.

// File: rtl/xbd_pkg.sv
package xbd_pkg;
  localparam int ADDR_W = 16;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_XRD   = 2'b01,
    KIND_XWR   = 2'b10,
    KIND_NONE  = 2'b11
  } acc_kind_e;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_PSRAM, TGT_PMEM, TGT_XIO, TGT_ATA0, TGT_ATA1, TGT_RTREG
  } tgt_e;

  localparam logic [ADDR_W-1:0] RT_LO    = 16'h0100;
  localparam logic [ADDR_W-1:0] RT_HI    = 16'h01FF;
  localparam logic [ADDR_W-1:0] TST_LO   = 16'h30F0;
  localparam logic [ADDR_W-1:0] TST_HI   = 16'h30F3;
  localparam logic [ADDR_W-1:0] ATA0_LO  = 16'h31F0;
  localparam logic [ADDR_W-1:0] ATA0_HI  = 16'h31F7;
  localparam logic [ADDR_W-1:0] ATA1_ADR = 16'h33F6;
  localparam logic [2:0]        ATA1_REG = 3'd6;
endpackage

// File: rtl/xbd_addr_map.sv
module xbd_addr_map
  import xbd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SRAM_LO = 16'h0400,
  parameter logic [ADDR_W-1:0] SRAM_HI = 16'h06FF
) (
  input  acc_kind_e          kind,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               sram_sel,
  input  logic               wr_to_prog,
  output tgt_e               tgt,
  output logic               stretch
);
  logic in_sram, prog_path;

  always_comb begin
    in_sram   = (addr >= SRAM_LO) && (addr <= SRAM_HI);
    prog_path = (kind == KIND_FETCH) || ((kind == KIND_XWR) && wr_to_prog);
    tgt       = TGT_NONE;
    stretch   = 1'b0;
    if (kind == KIND_NONE) begin
      tgt = TGT_NONE;
    end else if (prog_path) begin
      tgt = (in_sram && sram_sel) ? TGT_PSRAM : TGT_PMEM;
    end else if (addr >= RT_LO && addr <= RT_HI) begin
      tgt = TGT_RTREG;
    end else if (addr >= TST_LO && addr <= TST_HI) begin
      tgt = TGT_NONE;
    end else if (addr >= ATA0_LO && addr <= ATA0_HI) begin
      tgt     = TGT_ATA0;
      stretch = 1'b1;
    end else if (addr == ATA1_ADR) begin
      tgt     = TGT_ATA1;
      stretch = 1'b1;
    end else begin
      tgt     = TGT_XIO;
      stretch = 1'b1;
    end
  end
endmodule

// File: rtl/xbd_pulse_timer.sv
module xbd_pulse_timer #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  output logic             active
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (load && !act_q) begin
      act_d = 1'b1;
      cnt_d = len;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;

  assert_load_only_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q != '0) |=> (act_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/xbus_decoder.sv
module xbus_decoder
  import xbd_pkg::*;
#(
  parameter int MD_W       = 3,
  parameter int SRAM_BYTES = 768,
  parameter int SRAM_BASE  = 'h0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  input  logic [1:0]        acc_kind,
  input  logic [15:0]       acc_addr,
  input  logic              sram_sel,
  input  logic              wr_to_prog,
  input  logic [MD_W-1:0]   strobe_md,
  output logic              acc_ready,
  output logic [15:0]       ext_addr,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic              sram_en,
  output logic              sram_we,
  output logic [$clog2(SRAM_BYTES)-1:0] sram_addr,
  output logic              sfr_sel,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic [2:0]        ata_da
);
  localparam int SRAM_AW = $clog2(SRAM_BYTES);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(SRAM_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(SRAM_BASE + SRAM_BYTES - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  tgt_e              tgt_dec, tgt_q, tgt_d;
  logic              stretch_dec;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              active, accept;
  logic [MD_W-1:0]   len;
  acc_kind_e         kind_in;

  assign kind_in = acc_kind_e'(acc_kind);

  xbd_addr_map #(.SRAM_LO(WIN_LO), .SRAM_HI(WIN_HI)) u_map (
    .kind       (kind_in),
    .addr       (acc_addr),
    .sram_sel   (sram_sel),
    .wr_to_prog (wr_to_prog),
    .tgt        (tgt_dec),
    .stretch    (stretch_dec)
  );

  assign accept = acc_start && !active && (kind_in != KIND_NONE);
  assign len    = stretch_dec ? strobe_md : '0;

  xbd_pulse_timer #(.LEN_W(MD_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load   (accept),
    .len    (len),
    .active (active)
  );

  always_comb begin
    tgt_d  = tgt_q;
    wr_d   = wr_q;
    addr_d = addr_q;
    if (accept) begin
      tgt_d  = tgt_dec;
      wr_d   = (kind_in == KIND_XWR);
      addr_d = acc_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tgt_q  <= TGT_NONE;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      tgt_q  <= tgt_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
    end
  end

  logic io_tgt;
  assign io_tgt    = (tgt_q == TGT_XIO) || (tgt_q == TGT_ATA0) || (tgt_q == TGT_ATA1);
  assign acc_ready = !active;
  assign ext_addr  = addr_q;
  assign mem_rd_n  = !(active && tgt_q == TGT_PMEM && !wr_q);
  assign mem_wr_n  = !(active && tgt_q == TGT_PMEM && wr_q);
  assign io_rd_n   = !(active && io_tgt && !wr_q);
  assign io_wr_n   = !(active && io_tgt && wr_q);
  assign sram_en   = active && tgt_q == TGT_PSRAM;
  assign sram_we   = sram_en && wr_q;
  assign sram_addr = SRAM_AW'(addr_q - WIN_LO);
  assign sfr_sel   = active && tgt_q == TGT_RTREG;
  assign ata_cs0_n = !(active && tgt_q == TGT_ATA0);
  assign ata_cs1_n = !(active && tgt_q == TGT_ATA1);
  assign ata_da    = !active               ? 3'd0 :
                     (tgt_q == TGT_ATA0)   ? addr_q[2:0] :
                     (tgt_q == TGT_ATA1)   ? ATA1_REG : 3'd0;

  assert_sram_no_ext_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    sram_en |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n));
  assert_ata0_with_io_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ata_cs0_n |-> (!io_rd_n || !io_wr_n));
  assert_ata1_reg_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ata_cs1_n |-> (ata_da == 3'd6 && (!io_rd_n || !io_wr_n)));
  assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_start && acc_ready && (acc_kind == 2'b01 || (acc_kind == 2'b10 && !wr_to_prog))
     && acc_addr >= 16'h30F0 && acc_addr <= 16'h30F3)
    |=> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && ata_cs0_n && ata_cs1_n
         && !sram_en && !sfr_sel));
  assert_io_holds_ready_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!io_rd_n || !io_wr_n) |-> !acc_ready);
  assert_mem_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!mem_rd_n || !mem_wr_n || sram_en || sfr_sel) |=> acc_ready);
  assert_busy_ignores_start_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!acc_ready && acc_start) |=> $stable(ext_addr));
endmodule

// File: tb/tb_xbus_decoder.sv
module tb_xbus_decoder;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        mrd, mwr, ird, iwr, sen, swe, sfr, cs0, cs1;
    logic [2:0]  da;
    logic [15:0] ea;
    logic [9:0]  sa;
  } sig_t;

  typedef struct packed {
    sig_t       s;
    logic [3:0] width;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_start;
  logic [1:0] acc_kind;
  logic [15:0] acc_addr;
  logic sram_sel, wr_to_prog;
  logic [2:0] strobe_md;
  logic acc_ready;
  logic [15:0] ext_addr;
  logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, sram_en, sram_we, sfr_sel;
  logic [9:0] sram_addr;
  logic ata_cs0_n, ata_cs1_n;
  logic [2:0] ata_da;

  int vectors = 0;
  int errors  = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_decoder dut (
    .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .sram_sel(sram_sel), .wr_to_prog(wr_to_prog),
    .strobe_md(strobe_md), .acc_ready(acc_ready), .ext_addr(ext_addr),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr), .sfr_sel(sfr_sel),
    .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da)
  );

  function automatic sig_t observe();
    sig_t s;
    s.mrd = mem_rd_n; s.mwr = mem_wr_n; s.ird = io_rd_n; s.iwr = io_wr_n;
    s.sen = sram_en; s.swe = sram_we; s.sfr = sfr_sel;
    s.cs0 = ata_cs0_n; s.cs1 = ata_cs1_n; s.da = ata_da; s.ea = ext_addr;
    s.sa = sram_en ? sram_addr : 10'd0;
    return s;
  endfunction

  // expected outcome straight from the requirements
  function automatic exp_t predict(input logic [1:0] k, input logic [15:0] a,
                                   input logic ssel, input logic wtp, input logic [2:0] md);
    exp_t e;
    logic prog, inwin;
    e.s = '{mrd:1, mwr:1, ird:1, iwr:1, sen:0, swe:0, sfr:0, cs0:1, cs1:1,
            da:3'd0, ea:a, sa:10'd0};
    e.width = 4'd1;
    prog  = (k == 2'b00) || (k == 2'b10 && wtp);
    inwin = (a >= 16'h0400 && a <= 16'h06FF);
    if (prog) begin
      if (inwin && ssel) begin
        e.s.sen = 1; e.s.swe = (k == 2'b10); e.s.sa = 10'(a - 16'h0400);   // R2, R3
      end else if (k == 2'b10) e.s.mwr = 0;                                // R3
      else e.s.mrd = 0;                                                    // R1
    end else if (a >= 16'h0100 && a <= 16'h01FF) begin
      e.s.sfr = 1;                                                         // R8
    end else if (a >= 16'h30F0 && a <= 16'h30F3) begin
      ;                                                                    // R7
    end else begin
      if (k == 2'b10) e.s.iwr = 0; else e.s.ird = 0;                       // R4, R9
      e.width = 4'd1 + 4'(md);
      if (a >= 16'h31F0 && a <= 16'h31F7) begin e.s.cs0 = 0; e.s.da = a[2:0]; end // R5
      else if (a == 16'h33F6) begin e.s.cs1 = 0; e.s.da = 3'd6; end        // R6
    end
    return e;
  endfunction

  task automatic do_acc(input logic [1:0] k, input logic [15:0] a, input logic [2:0] md);
    @(negedge clk);
    acc_kind = k; acc_addr = a; strobe_md = md; acc_start = 1'b1;
    q.push_back(predict(k, a, sram_sel, wr_to_prog, md));
    @(negedge clk);
    acc_start = 1'b0;
    while (!acc_ready) @(negedge clk);
  endtask

  // monitor / scoreboard
  int   win_len = 0;
  exp_t cur;
  sig_t first;
  always @(negedge clk) begin
    if (rst_n && !acc_ready) begin
      if (win_len == 0) begin
        first = observe();
        vectors++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R11 unexpected access window: got %h expected none", first);
          cur = '0;
        end else begin
          cur = q.pop_front();
          if (first !== cur.s) begin
            errors++;
            $display("FAIL R1-R8 signature addr=%h: got %h expected %h", cur.s.ea, first, cur.s);
          end
        end
      end else if (observe() !== first) begin
        errors++;
        $display("FAIL R9 strobe not stable in window: got %h expected %h", observe(), first);
      end
      win_len++;
    end else if (win_len != 0) begin
      vectors++;
      if (win_len != int'(cur.width)) begin
        errors++;
        $display("FAIL R9/R10 width addr=%h: got %0d expected %0d", cur.s.ea, win_len, cur.width);
      end
      win_len = 0;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  logic [15:0] xlist [17] = '{16'h00FF, 16'h0100, 16'h01FF, 16'h0200, 16'h30EF, 16'h30F0,
                              16'h30F3, 16'h30F4, 16'h31EF, 16'h31F0, 16'h31F7, 16'h31F8,
                              16'h33F5, 16'h33F6, 16'h33F7, 16'h0400, 16'h06FF};
  logic [15:0] flist [6]  = '{16'h0000, 16'h03FF, 16'h0400, 16'h06FF, 16'h0700, 16'hFFFF};

  initial begin
    rst_n = 1'b0; acc_start = 1'b0; acc_kind = 2'b00; acc_addr = '0;
    sram_sel = 1'b0; wr_to_prog = 1'b0; strobe_md = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    vectors++;
    if ({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, ata_cs0_n, ata_cs1_n, sram_en, sfr_sel, acc_ready}
        !== 9'b111111001) begin
      errors++;
      $display("FAIL R12 reset state: got %b expected 111111001",
               {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, ata_cs0_n, ata_cs1_n, sram_en, sfr_sel, acc_ready});
    end

    // R1..R8 boundary sweep under both SRAM-select and write-redirect settings
    for (int c = 0; c < 4; c++) begin
      sram_sel = c[0]; wr_to_prog = c[1];
      foreach (flist[i]) do_acc(2'b00, flist[i], 3'd1);
      foreach (xlist[i]) do_acc(2'b01, xlist[i], 3'd2);
      foreach (xlist[i]) do_acc(2'b10, xlist[i], 3'd0);
    end

    // R9 strobe width for every timing value, plain I/O and both disk selects
    sram_sel = 1'b0; wr_to_prog = 1'b0;
    for (int m = 0; m < 8; m++) begin
      do_acc(2'b01, 16'h5000, 3'(m));
      do_acc(2'b10, 16'h31F3, 3'(m));
      do_acc(2'b01, 16'h33F6, 3'(m));
    end

    // R11: second start while a stretched strobe runs
    @(negedge clk);
    acc_kind = 2'b01; acc_addr = 16'h5A5A; strobe_md = 3'd3; acc_start = 1'b1;
    q.push_back(predict(2'b01, 16'h5A5A, sram_sel, wr_to_prog, 3'd3));
    @(negedge clk);
    acc_kind = 2'b10; acc_addr = 16'h31F0; strobe_md = 3'd7;
    @(negedge clk);
    acc_start = 1'b0;
    while (!acc_ready) @(negedge clk);
    // R11: kind 2'b11 never starts an access
    @(negedge clk);
    acc_kind = 2'b11; acc_addr = 16'h1234; acc_start = 1'b1;
    @(negedge clk);
    acc_start = 1'b0;
    repeat (3) @(negedge clk);
    vectors++;
    if (!acc_ready || q.size() != 0) begin
      errors++;
      $display("FAIL R11 ignored start: got ready=%b pending=%0d expected ready=1 pending=0",
               acc_ready, q.size());
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule